// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Software Refill

This block caches virtual-to-physical page translations in a small, fully associative store. A lookup takes a virtual address and an access type. It compares the virtual page number against every valid entry at the same time. One cycle later it reports one of four outcomes:

- a hit, with the physical address;
- a miss, which serves as the trap that asks software to refill;
- a protection fault;
- a multi-hit error.

The block never walks a page table and never picks a victim. Software chooses the entry index and writes every field of that entry through a refill port. Software can read any entry back, clear all reference bits at once, and invalidate every entry when the process changes.

Each entry holds the following fields:

- a virtual page number;
- a physical page number;
- three access-right bits;
- valid, dirty and referenced bits.

Hardware sets the referenced bit whenever an entry is matched, which gives software a basis for approximating least-recently-used replacement. Hardware sets the dirty bit when a permitted store hits the entry, so software knows which pages need writing back.

Top module: `tlb_sw_refill`

## Requirements
- R1: After reset every entry reads back with valid, dirty and referenced at 0, all lookup outputs are 0, and any lookup reports a miss.
- R2: A lookup presented while `lk_valid_i` is high is answered at the next clock edge. `lk_done_o` goes high there. On a permitted single match, `lk_hit_o` goes high and `lk_paddr_o` holds the physical page number followed by the untranslated low `PAGE_W` bits of the virtual address.
- R3: A lookup that matches no valid entry sets `lk_miss_o` only, with `lk_paddr_o` at 0, and changes no entry.
- R4: Rights are encoded as bit 0 = read, bit 1 = write, bit 2 = execute. Access codes are 0 = load (needs read), 1 = store (needs write), 2 = fetch (needs execute), and 3 = never permitted. A single match whose access is not permitted sets `lk_fault_o` instead of `lk_hit_o`, with `lk_paddr_o` at 0.
- R5: A single match sets the matched entry's referenced bit, whether the result is a hit or a fault.
- R6: The dirty bit is set only by a store that hits the entry with write permission. A faulting store leaves it unchanged.
- R7: `clr_ref_i` clears every referenced bit at the clock edge. An entry matched in the same cycle ends with its referenced bit set.
- R8: `inv_all_i` clears every valid bit at the clock edge. A refill written in the same cycle still installs its entry with the written valid bit.
- R9: A lookup in the same cycle as a refill of the matched entry is answered from the entry's old contents.
- R10: When more than one valid entry matches, only `lk_multi_o` is set. No referenced or dirty bit changes. Hit, miss and fault are mutually exclusive at all times.
- R11: The read port returns all fields of the entry named by `rd_idx_i` combinationally, and shows refills and hardware updates from the next cycle.
- R12: A refill of an entry takes precedence over the referenced and dirty updates that a lookup hitting the same entry would make in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Lookup virtual address |
| lk_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_done_o | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit_o | output | 1 | Permitted single match |
| lk_miss_o | output | 1 | No match; refill trap |
| lk_fault_o | output | 1 | Protection fault |
| lk_multi_o | output | 1 | More than one entry matched |
| lk_paddr_o | output | PA_W | Physical address on hit, otherwise 0 |
| wr_en_i | input | 1 | Refill write strobe |
| wr_idx_i | input | IDX_W | Refill entry index |
| wr_vpn_i | input | VA_W-PAGE_W | Refill virtual page number |
| wr_ppn_i | input | PA_W-PAGE_W | Refill physical page number |
| wr_rights_i | input | 3 | Refill rights {x,w,r} |
| wr_valid_i | input | 1 | Refill valid bit |
| wr_dirty_i | input | 1 | Refill dirty bit |
| wr_ref_i | input | 1 | Refill referenced bit |
| inv_all_i | input | 1 | Clear all valid bits |
| clr_ref_i | input | 1 | Clear all referenced bits |
| rd_idx_i | input | IDX_W | Read-back entry index |
| rd_vpn_o | output | VA_W-PAGE_W | Read-back virtual page number |
| rd_ppn_o | output | PA_W-PAGE_W | Read-back physical page number |
| rd_rights_o | output | 3 | Read-back rights |
| rd_valid_o | output | 1 | Read-back valid bit |
| rd_dirty_o | output | 1 | Read-back dirty bit |
| rd_ref_o | output | 1 | Read-back referenced bit |

## Verification
Some behaviours are checked by assertions on every cycle:

- hit, miss, fault and multi-hit are mutually exclusive;
- result flags stay low without a pending lookup;
- a hit passes the page offset through unchanged;
- a dirty or referenced bit rises only after a matching update or a refill;
- invalidate-all and clear-all leave the expected bits at zero.

Other behaviours need the bench's scenarios, because they depend on the values software wrote:

- the exact translated address;
- the permission decision for each rights and access pairing;
- same-cycle refill against lookup returning old contents;
- refill winning over hardware updates;
- multi-hit suppressing all state changes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int RIGHTS_W = 3;
  localparam int RIGHT_R  = 0;
  localparam int RIGHT_W  = 1;
  localparam int RIGHT_X  = 2;

  function automatic logic acc_allowed(input logic [RIGHTS_W-1:0] rights, input acc_e acc);
    case (acc)
      ACC_LOAD:  acc_allowed = rights[RIGHT_R];
      ACC_STORE: acc_allowed = rights[RIGHT_W];
      ACC_FETCH: acc_allowed = rights[RIGHT_X];
      default:   acc_allowed = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [VPN_W-1:0]    wr_vpn_i,
  input  logic [PPN_W-1:0]    wr_ppn_i,
  input  logic [RIGHTS_W-1:0] wr_rights_i,
  input  logic                wr_valid_i,
  input  logic                wr_dirty_i,
  input  logic                wr_ref_i,
  input  logic                inv_all_i,
  input  logic                clr_ref_i,
  input  logic [ENTRIES-1:0]  set_ref_i,
  input  logic [ENTRIES-1:0]  set_dirty_i,
  output logic [VPN_W-1:0]    vpn_o    [ENTRIES],
  output logic [PPN_W-1:0]    ppn_o    [ENTRIES],
  output logic [RIGHTS_W-1:0] rights_o [ENTRIES],
  output logic [ENTRIES-1:0]  valid_o,
  output logic [ENTRIES-1:0]  dirty_o,
  output logic [ENTRIES-1:0]  ref_o
);
  logic [ENTRIES-1:0] wr_sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign wr_sel[i] = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_o[i]    <= '0;
        ppn_o[i]    <= '0;
        rights_o[i] <= '0;
        valid_o[i]  <= 1'b0;
        dirty_o[i]  <= 1'b0;
        ref_o[i]    <= 1'b0;
      end else if (wr_sel[i]) begin
        // refill wins over every hardware update
        vpn_o[i]    <= wr_vpn_i;
        ppn_o[i]    <= wr_ppn_i;
        rights_o[i] <= wr_rights_i;
        valid_o[i]  <= wr_valid_i;
        dirty_o[i]  <= wr_dirty_i;
        ref_o[i]    <= wr_ref_i;
      end else begin
        if (inv_all_i)      valid_o[i] <= 1'b0;
        if (set_ref_i[i])   ref_o[i]   <= 1'b1;
        else if (clr_ref_i) ref_o[i]   <= 1'b0;
        if (set_dirty_i[i]) dirty_o[i] <= 1'b1;
      end
    end

    // R6
    dirty_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dirty_o[i]) |-> $past(set_dirty_i[i] || wr_sel[i]));

    // R5
    ref_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ref_o[i]) |-> $past(set_ref_i[i] || wr_sel[i]));
  end

  // R8
  inv_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i && !wr_en_i |=> valid_o == '0);

  // R7
  clr_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ref_i && !wr_en_i && (set_ref_i == '0) |=> ref_o == '0);
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic [VPN_W-1:0]    lk_vpn_i,
  input  logic [VPN_W-1:0]    vpn_i    [ENTRIES],
  input  logic [PPN_W-1:0]    ppn_i    [ENTRIES],
  input  logic [RIGHTS_W-1:0] rights_i [ENTRIES],
  input  logic [ENTRIES-1:0]  valid_i,
  output logic [ENTRIES-1:0]  hit_vec_o,
  output logic                any_o,
  output logic                multi_o,
  output logic [PPN_W-1:0]    ppn_o,
  output logic [RIGHTS_W-1:0] rights_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec_o[i] = valid_i[i] && (vpn_i[i] == lk_vpn_i);
  end

  // OR-reduce selected fields; only meaningful on a single match
  always_comb begin
    ppn_o    = '0;
    rights_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) begin
        ppn_o    = ppn_o | ppn_i[i];
        rights_o = rights_o | rights_i[i];
      end
    end
  end

  assign any_o   = |hit_vec_o;
  assign multi_o = any_o && !$onehot(hit_vec_o);
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp #(
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  localparam int PPN_W = PA_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              any_i,
  input  logic              multi_i,
  input  logic              allowed_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [PAGE_W-1:0] off_i,
  output logic              done_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic              multi_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic single, hit_d;
  assign single = any_i && !multi_i;
  assign hit_d  = req_i && single && allowed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      fault_o <= 1'b0;
      multi_o <= 1'b0;
      paddr_o <= '0;
    end else begin
      done_o  <= req_i;
      hit_o   <= hit_d;
      miss_o  <= req_i && !any_i;
      fault_o <= req_i && single && !allowed_i;
      multi_o <= req_i && multi_i;
      paddr_o <= hit_d ? {ppn_i, off_i} : '0;
    end
  end

  // R10
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, miss_o, fault_o, multi_o}));

  // R2
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(hit_o || miss_o || fault_o || multi_o));

  // R4
  paddr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> paddr_o == '0);
endmodule

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lk_valid_i,
  input  logic [VA_W-1:0]     lk_vaddr_i,
  input  logic [1:0]          lk_acc_i,
  output logic                lk_done_o,
  output logic                lk_hit_o,
  output logic                lk_miss_o,
  output logic                lk_fault_o,
  output logic                lk_multi_o,
  output logic [PA_W-1:0]     lk_paddr_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [VPN_W-1:0]    wr_vpn_i,
  input  logic [PPN_W-1:0]    wr_ppn_i,
  input  logic [RIGHTS_W-1:0] wr_rights_i,
  input  logic                wr_valid_i,
  input  logic                wr_dirty_i,
  input  logic                wr_ref_i,
  input  logic                inv_all_i,
  input  logic                clr_ref_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [VPN_W-1:0]    rd_vpn_o,
  output logic [PPN_W-1:0]    rd_ppn_o,
  output logic [RIGHTS_W-1:0] rd_rights_o,
  output logic                rd_valid_o,
  output logic                rd_dirty_o,
  output logic                rd_ref_o
);
  logic [VPN_W-1:0]    vpn_q    [ENTRIES];
  logic [PPN_W-1:0]    ppn_q    [ENTRIES];
  logic [RIGHTS_W-1:0] rights_q [ENTRIES];
  logic [ENTRIES-1:0]  valid_q, dirty_q, ref_q;
  logic [ENTRIES-1:0]  hit_vec, set_ref, set_dirty;
  logic                any_hit, multi_hit, single, allowed;
  logic [PPN_W-1:0]    ppn_sel;
  logic [RIGHTS_W-1:0] rights_sel;
  acc_e                acc;

  assign acc     = acc_e'(lk_acc_i);
  assign single  = any_hit && !multi_hit;
  assign allowed = acc_allowed(rights_sel, acc);

  assign set_ref   = (lk_valid_i && single) ? hit_vec : '0;
  assign set_dirty = (lk_valid_i && single && allowed && acc == ACC_STORE) ? hit_vec : '0;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_vpn_i    (wr_vpn_i),
    .wr_ppn_i    (wr_ppn_i),
    .wr_rights_i (wr_rights_i),
    .wr_valid_i  (wr_valid_i),
    .wr_dirty_i  (wr_dirty_i),
    .wr_ref_i    (wr_ref_i),
    .inv_all_i   (inv_all_i),
    .clr_ref_i   (clr_ref_i),
    .set_ref_i   (set_ref),
    .set_dirty_i (set_dirty),
    .vpn_o       (vpn_q),
    .ppn_o       (ppn_q),
    .rights_o    (rights_q),
    .valid_o     (valid_q),
    .dirty_o     (dirty_q),
    .ref_o       (ref_q)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
    .lk_vpn_i  (lk_vaddr_i[VA_W-1:PAGE_W]),
    .vpn_i     (vpn_q),
    .ppn_i     (ppn_q),
    .rights_i  (rights_q),
    .valid_i   (valid_q),
    .hit_vec_o (hit_vec),
    .any_o     (any_hit),
    .multi_o   (multi_hit),
    .ppn_o     (ppn_sel),
    .rights_o  (rights_sel)
  );

  tlb_resp #(.PA_W(PA_W), .PAGE_W(PAGE_W)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (lk_valid_i),
    .any_i     (any_hit),
    .multi_i   (multi_hit),
    .allowed_i (allowed),
    .ppn_i     (ppn_sel),
    .off_i     (lk_vaddr_i[PAGE_W-1:0]),
    .done_o    (lk_done_o),
    .hit_o     (lk_hit_o),
    .miss_o    (lk_miss_o),
    .fault_o   (lk_fault_o),
    .multi_o   (lk_multi_o),
    .paddr_o   (lk_paddr_o)
  );

  assign rd_vpn_o    = vpn_q[rd_idx_i];
  assign rd_ppn_o    = ppn_q[rd_idx_i];
  assign rd_rights_o = rights_q[rd_idx_i];
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_dirty_o  = dirty_q[rd_idx_i];
  assign rd_ref_o    = ref_q[rd_idx_i];

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[PAGE_W-1:0] == $past(lk_vaddr_i[PAGE_W-1:0]));

  // R10
  multi_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && multi_hit && !wr_en_i && !clr_ref_i |=> $stable(ref_q) && $stable(dirty_q));

  // R3
  miss_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !any_hit && !wr_en_i && !clr_ref_i && !inv_all_i
      |=> $stable(ref_q) && $stable(dirty_q) && $stable(valid_q));
endmodule

// File: tb/tb_tlb_sw_refill.sv
`timescale 1ns/1ps
module tb_tlb_sw_refill;
  localparam int ENTRIES = 16;
  localparam int VA_W = 32, PA_W = 32, PAGE_W = 12;
  localparam int VPN_W = VA_W - PAGE_W, PPN_W = PA_W - PAGE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0; logic [VA_W-1:0] lk_vaddr = '0; logic [1:0] lk_acc = '0;
  logic lk_done, lk_hit, lk_miss, lk_fault, lk_multi; logic [PA_W-1:0] lk_paddr;
  logic wr_en = 0; logic [IDX_W-1:0] wr_idx = '0; logic [VPN_W-1:0] wr_vpn = '0;
  logic [PPN_W-1:0] wr_ppn = '0; logic [2:0] wr_rights = '0;
  logic wr_valid = 0, wr_dirty = 0, wr_ref = 0, inv_all = 0, clr_ref = 0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [VPN_W-1:0] rd_vpn; logic [PPN_W-1:0] rd_ppn; logic [2:0] rd_rights;
  logic rd_valid, rd_dirty, rd_ref;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tlb_sw_refill #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_acc_i(lk_acc),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault),
    .lk_multi_o(lk_multi), .lk_paddr_o(lk_paddr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_ppn_i(wr_ppn),
    .wr_rights_i(wr_rights), .wr_valid_i(wr_valid), .wr_dirty_i(wr_dirty), .wr_ref_i(wr_ref),
    .inv_all_i(inv_all), .clr_ref_i(clr_ref),
    .rd_idx_i(rd_idx), .rd_vpn_o(rd_vpn), .rd_ppn_o(rd_ppn), .rd_rights_o(rd_rights),
    .rd_valid_o(rd_valid), .rd_dirty_o(rd_dirty), .rd_ref_o(rd_ref)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: inputs already driven away from the edge; pulses cleared after
  task automatic step();
    @(posedge clk); #1;
    lk_valid = 0; wr_en = 0; inv_all = 0; clr_ref = 0;
  endtask

  task automatic set_lk(input logic [VA_W-1:0] va, input logic [1:0] acc);
    lk_valid = 1; lk_vaddr = va; lk_acc = acc;
  endtask

  task automatic set_wr(input int idx, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [2:0] rights, input logic v, input logic d, input logic r);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_ppn = ppn;
    wr_rights = rights; wr_valid = v; wr_dirty = d; wr_ref = r;
  endtask

  // result flags {hit,miss,fault,multi}
  task automatic chk_res(input string req, input logic [3:0] flags, input logic [PA_W-1:0] pa);
    chk(req, "done", lk_done, 1'b1);
    chk(req, "flags", {lk_hit, lk_miss, lk_fault, lk_multi}, flags);
    chk(req, "paddr", lk_paddr, pa);
  endtask

  task automatic rd(input int idx); rd_idx = IDX_W'(idx); #0.1; endtask

  task automatic t_reset();
    chk("R1", "flags", {lk_done, lk_hit, lk_miss, lk_fault, lk_multi}, 5'b0);
    chk("R1", "paddr", lk_paddr, '0);
    for (int i = 0; i < ENTRIES; i++) begin
      rd(i);
      chk("R1", "valid/dirty/ref", {rd_valid, rd_dirty, rd_ref}, 3'b000);
    end
    set_lk(32'h0000_0000, 2'd0); step();
    chk_res("R1", 4'b0100, '0);
  endtask

  task automatic t_hit();
    set_wr(3, 20'h12345, 20'h00abc, 3'b011, 1, 0, 0); step();
    set_lk(32'h1234_5678, 2'd0); step();
    chk_res("R2", 4'b1000, 32'h00ab_c678);
    rd(3);
    chk("R5", "ref after load hit", rd_ref, 1'b1);
    chk("R6", "dirty after load hit", rd_dirty, 1'b0);
  endtask

  task automatic t_miss();
    clr_ref = 1; step();
    set_lk(32'h5555_5000, 2'd1); step();
    chk_res("R3", 4'b0100, '0);
    rd(3);
    chk("R3", "entry unchanged by miss", {rd_valid, rd_dirty, rd_ref}, 3'b100);
  endtask

  task automatic t_perm();
    set_wr(5, 20'h00100, 20'h00200, 3'b001, 1, 0, 0); step();
    set_wr(6, 20'h00300, 20'h00400, 3'b100, 1, 0, 0); step();
    rd(5);
    chk("R11", "read vpn", rd_vpn, 20'h00100);
    chk("R11", "read ppn", rd_ppn, 20'h00200);
    chk("R11", "read rights", rd_rights, 3'b001);
    set_lk(32'h0010_0010, 2'd1); step();
    chk_res("R4", 4'b0010, '0);
    rd(5);
    chk("R6", "dirty after faulting store", rd_dirty, 1'b0);
    chk("R5", "ref after fault", rd_ref, 1'b1);
    set_lk(32'h0010_0020, 2'd2); step();
    chk_res("R4", 4'b0010, '0);
    set_lk(32'h0010_0030, 2'd0); step();
    chk_res("R4", 4'b1000, 32'h0020_0030);
    set_lk(32'h0030_0fff, 2'd2); step();
    chk_res("R4", 4'b1000, 32'h0040_0fff);
    set_lk(32'h0030_0000, 2'd3); step();
    chk_res("R4", 4'b0010, '0);
    set_lk(32'h0030_0000, 2'd0); step();
    chk_res("R4", 4'b0010, '0);
  endtask

  task automatic t_dirty();
    set_lk(32'h1234_5004, 2'd1); step();
    chk_res("R6", 4'b1000, 32'h00ab_c004);
    rd(3);
    chk("R6", "dirty after store hit", rd_dirty, 1'b1);
  endtask

  task automatic t_clr_ref();
    clr_ref = 1; set_lk(32'h1234_5000, 2'd0); step();
    rd(3); chk("R7", "hit entry keeps ref", rd_ref, 1'b1);
    rd(5); chk("R7", "other entry cleared", rd_ref, 1'b0);
    rd(6); chk("R7", "other entry cleared", rd_ref, 1'b0);
  endtask

  task automatic t_same_cycle();
    set_wr(3, 20'h77777, 20'h11111, 3'b011, 1, 0, 0);
    set_lk(32'h1234_5abc, 2'd0); step();
    chk_res("R9", 4'b1000, 32'h00ab_cabc);
    set_lk(32'h7777_7001, 2'd0); step();
    chk_res("R9", 4'b1000, 32'h1111_1001);
    set_lk(32'h1234_5abc, 2'd0); step();
    chk_res("R9", 4'b0100, '0);
  endtask

  task automatic t_wr_override();
    set_wr(3, 20'h77777, 20'h11111, 3'b011, 1, 0, 0);
    set_lk(32'h7777_7002, 2'd1); step();
    chk_res("R12", 4'b1000, 32'h1111_1002);
    rd(3);
    chk("R12", "refill beats ref/dirty update", {rd_dirty, rd_ref}, 2'b00);
  endtask

  task automatic t_multi();
    set_wr(8, 20'h00100, 20'h00900, 3'b011, 1, 0, 0); step();
    clr_ref = 1; step();
    set_lk(32'h0010_0abc, 2'd1); step();
    chk_res("R10", 4'b0001, '0);
    rd(5); chk("R10", "entry5 ref/dirty", {rd_dirty, rd_ref}, 2'b00);
    rd(8); chk("R10", "entry8 ref/dirty", {rd_dirty, rd_ref}, 2'b00);
  endtask

  task automatic t_inv();
    inv_all = 1; set_wr(9, 20'h0abcd, 20'h0dcba, 3'b001, 1, 0, 0); step();
    rd(3); chk("R8", "entry3 valid", rd_valid, 1'b0);
    rd(5); chk("R8", "entry5 valid", rd_valid, 1'b0);
    rd(8); chk("R8", "entry8 valid", rd_valid, 1'b0);
    rd(9); chk("R8", "entry9 valid", rd_valid, 1'b1);
    set_lk(32'h0abc_d123, 2'd0); step();
    chk_res("R8", 4'b1000, 32'h0dcb_a123);
    set_lk(32'h0010_0000, 2'd0); step();
    chk_res("R8", 4'b0100, '0);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_hit();
    t_miss();
    t_perm();
    t_dirty();
    t_clr_ref();
    t_same_cycle();
    t_wr_override();
    t_multi();
    t_inv();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule